// File: doc/BRIEF.md
# Dual-Domain Timer Start/Stop Control

This block is a counter whose counting and start/stop logic run on their own timer clock. Software controls it from the system clock side. It has an enable bit, a start-mode field, a synchronizer-select bit, and one-cycle clear and capture commands. An external trigger line can start the counter, stop it, or gate it, depending on the start mode. Run state, counter MSB, trigger level and an event flag come back to the system side.

With the synchronizer-select bit set, every control input is retimed into the timer clock through a three-flop chain before it can affect counting. This covers the enable level, the trigger line and the commands. The fixed latency shifts start, stop and reset events equally, so the count sequence does not change. With the bit clear, the timer uses the enable level, the trigger and the commands directly. The trigger then gates or restarts counting without delay, which leaves collisions with the timer clock to the integrator. Timer-to-system status always passes through three system-clock flops.

Start mode and synchronizer select are configuration. They are changed only while the enable bit is clear, and single-cycle commands must be wider than one timer clock when unsynchronized.

Top module: `dtmr_ctrl`

## Requirements
- R1: After reset, en_o, run_sts, out_sts, ers_sts, int_flag, cap_val and tmr_cnt are all 0.
- R2: While en_o is 0, tmr_cnt does not change, whatever the ers input does.
- R3: In start mode 2'b00 with sync_en=1, the first counter increment lands on the 5th timer clock edge after the system edge that registers en_set. With sync_en=0 it lands on the 2nd. The gap of three edges is the control synchronizer.
- R4: On every timer clock, tmr_cnt either holds, steps up by exactly one (wrapping at 2^CNT_W), or returns to zero.
- R5: In start mode 2'b00, run_sts rises on the 6th system edge after the edge registering en_set with sync_en=1, and on the 3rd with sync_en=0. Status lags the timer by three system clocks.
- R6: In start mode 2'b01, setting the enable only arms the counter. A rising ers edge starts counting and a falling ers edge is a hardware stop.
- R7: In start mode 2'b10, a falling ers edge starts counting and a rising ers edge is a hardware stop.
- R8: In start mode 2'b11, the counter advances only while ers is high, and a low ers pauses it without clearing en_o. After ers falls, the counter makes exactly 3 more increments with sync_en=1 and none with sync_en=0.
- R9: A hardware stop clears en_o. Further ers edges do not restart counting until software sets the enable again.
- R10: int_flag sets on a start, a hardware stop or an executed clear command. A one-cycle int_clr pulse clears it when no event arrives in the same cycle.
- R11: clr_cmd returns tmr_cnt to 0. capt_cmd copies the counter value into cap_val.
- R12: out_sts reflects bit CNT_W-1 of the counter.
- R13: A software en_clr stops counting, and the count is then held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst | input | 1 | Synchronous active-high reset, system domain |
| en_set | input | 1 | One-cycle pulse setting the enable bit |
| en_clr | input | 1 | One-cycle pulse clearing the enable bit |
| start_mode | input | 2 | 00 software, 01 ers rise, 10 ers fall, 11 ers high level |
| sync_en | input | 1 | 1 selects synchronized control, 0 direct control |
| clr_cmd | input | 1 | One-cycle counter clear command |
| capt_cmd | input | 1 | One-cycle capture command |
| int_clr | input | 1 | Write-one pulse clearing int_flag |
| en_o | output | 1 | Enable bit |
| run_sts | output | 1 | Timer running, system domain |
| out_sts | output | 1 | Counter MSB, system domain |
| ers_sts | output | 1 | Trigger level as seen by the timer, system domain |
| int_flag | output | 1 | Event flag |
| cap_val | output | CNT_W | Captured count |
| tmr_clk | input | 1 | Timer clock |
| tmr_rst | input | 1 | Synchronous active-high reset, timer domain |
| ers | input | 1 | External start/stop trigger, asynchronous |
| tmr_cnt | output | CNT_W | Counter value, timer domain |

## Verification
The enable is written with the synchronizer on and with it off. The cycle of the first increment and the cycle of run_sts are measured in each case, which separates the three-clock timer-side delay from the three-clock status delay. The trigger is driven as rising-start, falling-start and high-level gating patterns. The rising and falling cases distinguish edge polarity and hardware stop from a mere pause. The gating pattern shows the trigger cutting the count directly, as opposed to after exactly three extra increments. A model of the count's legal steps is checked on every timer clock.

// File: rtl/dtmr_pkg.sv
`timescale 1ns/1ps
package dtmr_pkg;
  typedef enum logic [1:0] {
    START_SW   = 2'b00,
    START_RISE = 2'b01,
    START_FALL = 2'b10,
    START_HIGH = 2'b11
  } start_mode_e;
endpackage

// File: rtl/dtmr_lvl_sync.sv
`timescale 1ns/1ps
module dtmr_lvl_sync #(
  parameter int W      = 1,
  parameter int STAGES = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk) begin
    if (rst) st <= '0;
    else     st <= {st[STAGES-2:0], d};
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/dtmr_pulse_xfer.sv
`timescale 1ns/1ps
module dtmr_pulse_xfer #(
  parameter int STAGES = 3
) (
  input  logic src_clk,
  input  logic src_rst,
  input  logic src_pulse,
  input  logic dst_clk,
  input  logic dst_rst,
  output logic dst_pulse
);
  logic tog, tog_s, tog_q;

  always_ff @(posedge src_clk) begin
    if (src_rst) tog <= 1'b0;
    else         tog <= tog ^ src_pulse;
  end

  dtmr_lvl_sync #(.W(1), .STAGES(STAGES)) u_sync (
    .clk(dst_clk), .rst(dst_rst), .d(tog), .q(tog_s)
  );

  always_ff @(posedge dst_clk) begin
    if (dst_rst) tog_q <= 1'b0;
    else         tog_q <= tog_s;
  end

  assign dst_pulse = tog_s ^ tog_q;
endmodule

// File: rtl/dtmr_core.sv
`timescale 1ns/1ps
module dtmr_core
  import dtmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_t,
  input  logic             ers_t,
  input  start_mode_e      mode,
  input  logic             clr_t,
  input  logic             capt_t,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap_reg,
  output logic             run,
  output logic             out,
  output logic             start_p,
  output logic             stop_p,
  output logic             clr_p,
  output logic             capt_p
);
  logic ers_q, halted, run_nxt, stop_nxt, count_en;
  logic rise, fall;

  assign rise = ers_t & ~ers_q;
  assign fall = ~ers_t & ers_q;

  always_comb begin
    run_nxt  = run;
    stop_nxt = 1'b0;
    if (!en_t || halted) begin
      run_nxt = 1'b0;
    end else begin
      case (mode)
        START_RISE: begin
          if (!run && rise) run_nxt = 1'b1;
          else if (run && fall) begin run_nxt = 1'b0; stop_nxt = 1'b1; end
        end
        START_FALL: begin
          if (!run && fall) run_nxt = 1'b1;
          else if (run && rise) begin run_nxt = 1'b0; stop_nxt = 1'b1; end
        end
        default: run_nxt = 1'b1;
      endcase
    end
  end

  assign count_en = run && ((mode != START_HIGH) || ers_t);

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      halted  <= 1'b0;
      ers_q   <= 1'b0;
      start_p <= 1'b0;
      stop_p  <= 1'b0;
      clr_p   <= 1'b0;
      capt_p  <= 1'b0;
      cnt     <= '0;
      cap_reg <= '0;
    end else begin
      run     <= run_nxt;
      halted  <= en_t & (halted | stop_nxt);
      ers_q   <= ers_t;
      start_p <= run_nxt & ~run;
      stop_p  <= stop_nxt;
      clr_p   <= clr_t;
      capt_p  <= capt_t;
      if (clr_t)         cnt <= '0;
      else if (count_en) cnt <= cnt + 1'b1;
      if (capt_t) cap_reg <= cnt;
    end
  end

  assign out = cnt[CNT_W-1];

  // R2
  run_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    !en_t |=> !run);
  // R4
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!count_en && !clr_t) |=> $stable(cnt));
  // R3
  sw_start_chk: assert property (@(posedge clk) disable iff (rst)
    (en_t && mode == START_SW && !halted) |=> run);
  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !run);
endmodule

// File: rtl/dtmr_ctrl.sv
`timescale 1ns/1ps
module dtmr_ctrl
  import dtmr_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int STAGES = 3
) (
  input  logic             sys_clk,
  input  logic             sys_rst,
  input  logic             en_set,
  input  logic             en_clr,
  input  logic [1:0]       start_mode,
  input  logic             sync_en,
  input  logic             clr_cmd,
  input  logic             capt_cmd,
  input  logic             int_clr,
  output logic             en_o,
  output logic             run_sts,
  output logic             out_sts,
  output logic             ers_sts,
  output logic             int_flag,
  output logic [CNT_W-1:0] cap_val,
  input  logic             tmr_clk,
  input  logic             tmr_rst,
  input  logic             ers,
  output logic [CNT_W-1:0] tmr_cnt
);
  localparam int N_CMD = 2;
  localparam int N_EVT = 3;

  logic             en_reg, en_sync, ers_sync;
  logic             en_t, ers_t, clr_t, capt_t;
  logic [N_CMD-1:0] cmd_sys, cmd_tmr;
  logic [N_EVT-1:0] ev_tmr, ev_sys;
  logic [CNT_W-1:0] cap_reg;
  logic             run, out, start_p, stop_p, clr_p, capt_p;
  logic             evt_s, stop_s, capt_s;

  // system to timer: levels
  dtmr_lvl_sync #(.W(2), .STAGES(STAGES)) u_ctl_sync (
    .clk(tmr_clk), .rst(tmr_rst), .d({ers, en_reg}), .q({ers_sync, en_sync})
  );

  // system to timer: commands
  assign cmd_sys = {capt_cmd, clr_cmd};
  for (genvar g = 0; g < N_CMD; g++) begin : g_cmd
    dtmr_pulse_xfer #(.STAGES(STAGES)) u_x (
      .src_clk(sys_clk), .src_rst(sys_rst), .src_pulse(cmd_sys[g]),
      .dst_clk(tmr_clk), .dst_rst(tmr_rst), .dst_pulse(cmd_tmr[g])
    );
  end

  assign en_t   = sync_en ? en_sync    : en_reg;
  assign ers_t  = sync_en ? ers_sync   : ers;
  assign clr_t  = sync_en ? cmd_tmr[0] : clr_cmd;
  assign capt_t = sync_en ? cmd_tmr[1] : capt_cmd;

  dtmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(tmr_clk), .rst(tmr_rst), .en_t(en_t), .ers_t(ers_t),
    .mode(start_mode_e'(start_mode)), .clr_t(clr_t), .capt_t(capt_t),
    .cnt(tmr_cnt), .cap_reg(cap_reg), .run(run), .out(out),
    .start_p(start_p), .stop_p(stop_p), .clr_p(clr_p), .capt_p(capt_p)
  );

  // timer to system: events
  assign ev_tmr = {capt_p, stop_p, start_p | stop_p | clr_p};
  for (genvar g = 0; g < N_EVT; g++) begin : g_evt
    dtmr_pulse_xfer #(.STAGES(STAGES)) u_x (
      .src_clk(tmr_clk), .src_rst(tmr_rst), .src_pulse(ev_tmr[g]),
      .dst_clk(sys_clk), .dst_rst(sys_rst), .dst_pulse(ev_sys[g])
    );
  end
  assign evt_s  = ev_sys[0];
  assign stop_s = ev_sys[1];
  assign capt_s = ev_sys[2];

  // timer to system: levels
  dtmr_lvl_sync #(.W(3), .STAGES(STAGES)) u_sts_sync (
    .clk(sys_clk), .rst(sys_rst), .d({ers_t, out, run}),
    .q({ers_sts, out_sts, run_sts})
  );

  always_ff @(posedge sys_clk) begin
    if (sys_rst) begin
      en_reg   <= 1'b0;
      int_flag <= 1'b0;
      cap_val  <= '0;
    end else begin
      if (en_clr || stop_s) en_reg <= 1'b0;
      else if (en_set)      en_reg <= 1'b1;
      if (evt_s)        int_flag <= 1'b1;
      else if (int_clr) int_flag <= 1'b0;
      if (capt_s) cap_val <= cap_reg;
    end
  end

  assign en_o = en_reg;

  // R9
  hw_stop_clears_en_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
    stop_s |=> !en_reg);
  // R10
  evt_sets_flag_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
    evt_s |=> int_flag);
  // R10
  w1c_clears_flag_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
    (int_clr && !evt_s) |=> !int_flag);
  // R11
  capture_lands_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
    capt_s |=> (cap_val == $past(cap_reg)));
endmodule

// File: tb/dtmr_ctrl_tb.sv
`timescale 1ns/1ps
module dtmr_ctrl_tb_top;
  localparam int CNT_W = 8;

  logic sys_clk, sys_rst, tmr_clk, tmr_rst;
  logic en_set, en_clr, sync_en, clr_cmd, capt_cmd, int_clr, ers;
  logic [1:0] start_mode;
  logic en_o, run_sts, out_sts, ers_sts, int_flag;
  logic [CNT_W-1:0] cap_val, tmr_cnt;

  int vectors = 0;
  int miscompares = 0;
  bit mon_on = 0;
  int prev_cnt = 0;

  dtmr_ctrl #(.CNT_W(CNT_W), .STAGES(3)) dut_i (
    .sys_clk(sys_clk), .sys_rst(sys_rst), .en_set(en_set), .en_clr(en_clr),
    .start_mode(start_mode), .sync_en(sync_en), .clr_cmd(clr_cmd),
    .capt_cmd(capt_cmd), .int_clr(int_clr), .en_o(en_o), .run_sts(run_sts),
    .out_sts(out_sts), .ers_sts(ers_sts), .int_flag(int_flag), .cap_val(cap_val),
    .tmr_clk(tmr_clk), .tmr_rst(tmr_rst), .ers(ers), .tmr_cnt(tmr_cnt)
  );

  initial begin sys_clk = 0; forever #2.5 sys_clk = ~sys_clk; end
  initial begin tmr_clk = 0; #1.25; forever #2.5 tmr_clk = ~tmr_clk; end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // R4 reference: legal count steps, compared on every timer clock
  always @(negedge tmr_clk) begin
    if (mon_on) begin
      vectors++;
      if (!(tmr_cnt == prev_cnt || tmr_cnt == ((prev_cnt + 1) % (1 << CNT_W)) || tmr_cnt == 0)) begin
        miscompares++;
        $display("FAIL R4 step: actual %0d expected %0d or %0d or 0",
                 tmr_cnt, prev_cnt, (prev_cnt + 1) % (1 << CNT_W));
      end
    end
    prev_cnt = tmr_cnt;
  end

  initial begin
    #(5.0 * 150000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic sysw(input int n);
    repeat (n) @(posedge sys_clk);
    @(negedge sys_clk);
  endtask

  task automatic p_en_set();  @(negedge sys_clk) en_set = 1;  @(negedge sys_clk) en_set = 0;  endtask
  task automatic p_en_clr();  @(negedge sys_clk) en_clr = 1;  @(negedge sys_clk) en_clr = 0;  endtask
  task automatic p_clr();     @(negedge sys_clk) clr_cmd = 1; @(negedge sys_clk) clr_cmd = 0; endtask
  task automatic p_capt();    @(negedge sys_clk) capt_cmd = 1; @(negedge sys_clk) capt_cmd = 0; endtask
  task automatic p_int_clr(); @(negedge sys_clk) int_clr = 1; @(negedge sys_clk) int_clr = 0; endtask

  task automatic idle_clear();
    p_en_clr(); sysw(15); p_clr(); sysw(15); p_int_clr(); sysw(5);
  endtask

  // R3 and R5: measure first increment (timer edges) and run_sts rise (system edges)
  task automatic latency(input int exp_cnt, input int exp_run, input string t3, input string t5);
    int fc = 0;
    int fr = 0;
    @(negedge sys_clk) en_set = 1;
    @(posedge sys_clk);
    fork
      begin #1 en_set = 0; end
      begin
        for (int i = 1; i <= 12; i++) begin
          @(posedge tmr_clk); #0.5;
          if (tmr_cnt != 0 && fc == 0) fc = i;
        end
      end
      begin
        for (int i = 1; i <= 12; i++) begin
          @(posedge sys_clk); #0.5;
          if (run_sts && fr == 0) fr = i;
        end
      end
    join
    chk(t3, fc, exp_cnt);
    chk(t5, fr, exp_run);
  endtask

  int c;

  initial begin
    sys_rst = 1; tmr_rst = 1;
    en_set = 0; en_clr = 0; sync_en = 1; clr_cmd = 0; capt_cmd = 0; int_clr = 0;
    ers = 0; start_mode = 2'b00;
    repeat (6) @(posedge sys_clk);
    @(negedge sys_clk) begin sys_rst = 0; tmr_rst = 0; end
    mon_on = 1;
    sysw(2);

    // R1
    chk("R1 en_o", en_o, 0);
    chk("R1 run_sts", run_sts, 0);
    chk("R1 out_sts", out_sts, 0);
    chk("R1 ers_sts", ers_sts, 0);
    chk("R1 int_flag", int_flag, 0);
    chk("R1 cap_val", cap_val, 0);
    chk("R1 tmr_cnt", tmr_cnt, 0);

    // R2: trigger activity with enable clear
    for (int k = 0; k < 4; k++) begin ers = ~ers; sysw(8); end
    chk("R2 no count without enable", tmr_cnt, 0);
    ers = 0; sysw(10);

    // R3/R5 synchronized
    latency(5, 6, "R3 sync first increment", "R5 sync run_sts");
    idle_clear();
    // R3/R5 direct
    sync_en = 0; sysw(5);
    latency(2, 3, "R3 direct first increment", "R5 direct run_sts");
    idle_clear();
    sync_en = 1; sysw(5);
    chk("R11 clear to zero", tmr_cnt, 0);

    // R6 rising start, falling stop
    start_mode = 2'b01; p_en_set(); sysw(20);
    chk("R6 armed not counting", tmr_cnt, 0);
    chk("R6 enable armed", en_o, 1);
    ers = 1; sysw(20);
    chk("R6 counts after rise", tmr_cnt > 0, 1);
    chk("R10 flag on start", int_flag, 1);
    p_int_clr(); sysw(2);
    chk("R10 write-one clear", int_flag, 0);
    ers = 0; sysw(20);
    c = tmr_cnt; sysw(10);
    chk("R6 stopped on fall", tmr_cnt, c);
    chk("R9 enable auto-cleared", en_o, 0);
    chk("R10 flag on stop", int_flag, 1);
    ers = 1; sysw(10); ers = 0; sysw(10); ers = 1; sysw(15);
    chk("R9 no restart after stop", tmr_cnt, c);
    chk("R2 ers_sts follows trigger", ers_sts, 1);
    idle_clear();

    // R7 falling start, rising stop (ers is high here)
    start_mode = 2'b10; p_en_set(); sysw(20);
    chk("R7 armed not counting", tmr_cnt, 0);
    ers = 0; sysw(20);
    chk("R7 counts after fall", tmr_cnt > 0, 1);
    ers = 1; sysw(20);
    c = tmr_cnt; sysw(10);
    chk("R7 stopped on rise", tmr_cnt, c);
    chk("R9 enable auto-cleared mode 10", en_o, 0);
    idle_clear();

    // R8 level gating, synchronized: 3 extra counts
    ers = 0; start_mode = 2'b11; p_en_set(); sysw(20);
    chk("R8 low level holds", tmr_cnt, 0);
    ers = 1; sysw(20);
    @(negedge tmr_clk) ers = 0;
    c = tmr_cnt;
    repeat (6) @(posedge tmr_clk); #0.5;
    chk("R8 sync extra counts", tmr_cnt, (c + 3) % 256);
    sysw(10);
    chk("R8 pause keeps enable", en_o, 1);
    idle_clear();

    // R8 level gating, direct: no extra counts
    sync_en = 0; sysw(5);
    ers = 1; p_en_set(); sysw(20);
    @(negedge tmr_clk) ers = 0;
    c = tmr_cnt;
    repeat (6) @(posedge tmr_clk); #0.5;
    chk("R8 direct gate immediate", tmr_cnt, c);
    sysw(5);
    // R11 capture while paused
    p_capt(); sysw(20);
    chk("R11 capture value", cap_val, c);
    ers = 1; sysw(10);
    chk("R8 resumes on high", tmr_cnt > c, 1);
    ers = 0;
    idle_clear();
    sync_en = 1; sysw(5);

    // R10 flag on clear event
    p_clr(); sysw(20);
    chk("R10 flag on clear", int_flag, 1);
    p_int_clr(); sysw(3);

    // R12 / R13
    start_mode = 2'b00; p_en_set(); sysw(150);
    p_en_clr(); sysw(10);
    c = tmr_cnt;
    chk("R12 counter MSB set", (c >> (CNT_W - 1)) & 1, 1);
    chk("R12 out_sts mirrors MSB", out_sts, 1);
    sysw(20);
    chk("R13 held after software clear", tmr_cnt, c);
    chk("R13 enable clear", en_o, 0);
    chk("R13 run_sts low", run_sts, 0);

    summary();
    $finish;
  end
endmodule